// File: doc/BRIEF.md
# NAND Feature Command Sequencer

This block runs the two feature-access transactions of a raw NAND flash bus for a host. For a set transaction the host supplies a feature address and four parameter bytes. For a get transaction the host supplies a feature address and receives four bytes back. Each transaction starts with one command cycle and one address cycle. A set then writes its four bytes. A get waits for the device and then reads four bytes. The host sees `busy` for the whole transaction and a one-cycle `done` at the end. `err` accompanies `done` when the device never reported ready.

All bus gaps are parameters given in nanoseconds and converted to clock cycles at elaboration. The address-to-data gap is applied before the first parameter write of a set. The write-to-busy gap is applied after the last byte of a set and after the address of a get. After that gap the block waits for the ready/busy line. When no ready/busy line exists, a fixed programmable delay is used instead.

A second request port is a shortcut for the device's array-mode feature. It turns on-die error correction on or off with one bit. The block keeps a registered flag that shows whether on-die correction is currently enabled.

Top module: `nand_feat_seq`

## Requirements
- R1: A set transaction drives opcode 0xEF with `nand_cle` high, then exactly one address cycle with `nand_ale` high carrying `req_addr`, then four data writes. The data writes carry `req_wdata[7:0]` first and `req_wdata[31:24]` last. Every byte is valid at the rising edge of `nand_we_n`.
- R2: A get transaction drives opcode 0xEE, then exactly one address cycle, then four `nand_re_n` read strobes. The byte read on the first strobe lands in `rdata[7:0]` and the byte read on the fourth lands in `rdata[31:24]`. `rdata` is valid in the `done` cycle.
- R3: Between the rising `nand_we_n` of the address cycle and the rising `nand_we_n` of the first parameter write there are at least ceil(T_ADL_NS/CLK_PERIOD_NS) clock cycles.
- R4: With USE_RB=1, after the write-to-busy gap the block issues no read strobe and no `done` until `nand_rb_n` has returned high.
- R5: With USE_RB=0, `nand_rb_n` is ignored and a fixed wait of ceil(T_FIX_NS/CLK_PERIOD_NS) cycles replaces the ready wait.
- R6: If `nand_rb_n` stays low for TIMEOUT_CYC cycles, the transaction ends with `done` and `err` both high and no read strobes are issued.
- R7: `busy` rises in the cycle after a request is accepted and stays high through the `done` cycle. Any request that arrives while `busy` is high is ignored.
- R8: An ECC request sends a set transaction to feature address 0x90. The parameters are 0x08,0x00,0x00,0x00 when `ecc_req_en`=1 and all zeros when it is 0. If an ECC request and a plain request arrive in the same cycle, the ECC request wins.
- R9: `ecc_on` resets to 0. It changes only in the cycle after an ECC transaction completes without error, and it then takes the requested value.
- R10: While idle, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high and `nand_cle`, `nand_ale` and `nand_dq_oe` are low. `nand_cle` and `nand_ale` are never high together. `nand_we_n` and `nand_re_n` are never low together.
- R11: `done` is high for exactly one cycle per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Plain feature request, sampled while idle |
| req_write | input | 1 | 1 selects a set transaction, 0 selects a get |
| req_addr | input | 8 | Feature address |
| req_wdata | input | 32 | Parameter bytes; bits 7:0 are sent first |
| ecc_req_valid | input | 1 | On-die ECC mode request |
| ecc_req_en | input | 1 | 1 enables on-die ECC, 0 disables it |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready timeout, valid with done |
| rdata | output | 32 | Bytes returned by a get; first byte in bits 7:0 |
| ecc_on | output | 1 | On-die ECC currently enabled |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 8 | Data from the device |
| nand_rb_n | input | 1 | Ready/busy from the device, low while busy |

## Verification
The assertions assume the device pulls `nand_rb_n` low well inside the write-to-busy gap. They also assume that requests and device data are stable around the clock edge. The bench's device model drops ready/busy one cycle after the triggering strobe and holds it low for a programmed length, which is either below or far above the timeout. The bench changes all host inputs at the falling clock edge. Device read data is driven only while a read strobe is low.

// File: rtl/nfs_pkg.sv
`timescale 1ns/1ps
package nfs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ADR, ST_ADL, ST_WR, ST_WB, ST_RDY, ST_RD, ST_DONE
  } nfs_state_e;

  localparam logic [7:0]  OPC_SET      = 8'hEF;
  localparam logic [7:0]  OPC_GET      = 8'hEE;
  localparam logic [7:0]  FA_ARRAY_OP  = 8'h90;
  localparam logic [31:0] ECC_ON_PARM  = 32'h0000_0008;
  localparam logic [31:0] ECC_OFF_PARM = 32'h0000_0000;

  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/nfs_delay.sv
`timescale 1ns/1ps
module nfs_delay #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/nfs_sync.sv
`timescale 1ns/1ps
module nfs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/nfs_seq.sv
`timescale 1ns/1ps
module nfs_seq
  import nfs_pkg::*;
#(
  parameter int STROBE_CYC = 1,
  parameter int ADL_CYC    = 4,
  parameter int WB_CYC     = 7,
  parameter int WAIT_CYC   = 200,
  parameter int USE_RB     = 1,
  parameter int CW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [7:0]    req_addr,
  input  logic [31:0]   req_wdata,
  input  logic          ecc_req_valid,
  input  logic          ecc_req_en,
  input  logic          rb_ready,
  input  logic [7:0]    dq_i,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [7:0]    dq_o,
  output logic          dq_oe,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [31:0]   rdata,
  output logic          txn_ecc,
  output logic          txn_ecc_en
);

  localparam logic [CW-1:0] L_STROBE = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] L_ADL    = CW'(ADL_CYC - 1);
  localparam logic [CW-1:0] L_WB     = CW'(WB_CYC - 1);
  localparam logic [CW-1:0] L_WAIT   = CW'(WAIT_CYC - 1);

  nfs_state_e  state_q, state_d;
  logic        hi_q, hi_d;
  logic [1:0]  idx_q, idx_d;
  logic        wr_q, wr_d, ecc_q, ecc_d, ecen_q, ecen_d, err_q, err_d;
  logic [7:0]  addr_q, addr_d;
  logic [31:0] wdata_q, wdata_d, rdata_q, rdata_d;
  logic        strobe_st, ready_go;

  assign strobe_st = (state_q == ST_CMD) || (state_q == ST_ADR) ||
                     (state_q == ST_WR)  || (state_q == ST_RD);

  always_comb begin
    state_d = state_q; hi_d = hi_q; idx_d = idx_q;
    wr_d = wr_q; ecc_d = ecc_q; ecen_d = ecen_q; err_d = err_q;
    addr_d = addr_q; wdata_d = wdata_q; rdata_d = rdata_q;
    tmr_load = 1'b0; tmr_val = '0; ready_go = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ecc_req_valid || req_valid) begin
          ecc_d   = ecc_req_valid;
          ecen_d  = ecc_req_en;
          wr_d    = ecc_req_valid ? 1'b1 : req_write;
          addr_d  = ecc_req_valid ? FA_ARRAY_OP : req_addr;
          wdata_d = ecc_req_valid ? (ecc_req_en ? ECC_ON_PARM : ECC_OFF_PARM)
                                  : req_wdata;
          err_d = 1'b0; hi_d = 1'b0; idx_d = 2'd0;
          state_d = ST_CMD; tmr_load = 1'b1; tmr_val = L_STROBE;
        end
      end
      ST_CMD, ST_ADR, ST_WR, ST_RD: begin
        if (tmr_expired) begin
          tmr_load = 1'b1; tmr_val = L_STROBE;
          if (!hi_q) begin
            hi_d = 1'b1;
            if (state_q == ST_RD) rdata_d[{idx_q, 3'b000} +: 8] = dq_i;
          end else begin
            hi_d = 1'b0;
            case (state_q)
              ST_CMD: state_d = ST_ADR;
              ST_ADR: begin
                state_d = wr_q ? ST_ADL : ST_WB;
                tmr_val = wr_q ? L_ADL : L_WB;
              end
              ST_WR: begin
                if (idx_q == 2'd3) begin state_d = ST_WB; tmr_val = L_WB; end
                else idx_d = idx_q + 2'd1;
              end
              default: begin
                if (idx_q == 2'd3) begin state_d = ST_DONE; tmr_load = 1'b0; end
                else idx_d = idx_q + 2'd1;
              end
            endcase
          end
        end
      end
      ST_ADL: if (tmr_expired) begin
        state_d = ST_WR; idx_d = 2'd0; tmr_load = 1'b1; tmr_val = L_STROBE;
      end
      ST_WB: if (tmr_expired) begin
        state_d = ST_RDY; tmr_load = 1'b1; tmr_val = L_WAIT;
      end
      ST_RDY: begin
        if (USE_RB != 0) begin
          if (rb_ready) ready_go = 1'b1;
          else if (tmr_expired) begin err_d = 1'b1; state_d = ST_DONE; end
        end else if (tmr_expired) ready_go = 1'b1;
        if (ready_go) begin
          if (wr_q) state_d = ST_DONE;
          else begin
            state_d = ST_RD; idx_d = 2'd0; hi_d = 1'b0;
            tmr_load = 1'b1; tmr_val = L_STROBE;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; hi_q <= 1'b0; idx_q <= 2'd0;
      wr_q <= 1'b0; ecc_q <= 1'b0; ecen_q <= 1'b0; err_q <= 1'b0;
      addr_q <= 8'h00; wdata_q <= '0; rdata_q <= '0;
    end else begin
      state_q <= state_d; hi_q <= hi_d; idx_q <= idx_d;
      wr_q <= wr_d; ecc_q <= ecc_d; ecen_q <= ecen_d; err_q <= err_d;
      addr_q <= addr_d; wdata_q <= wdata_d; rdata_q <= rdata_d;
    end
  end

  assign ce_n  = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign cle   = (state_q == ST_CMD);
  assign ale   = (state_q == ST_ADR);
  assign dq_oe = strobe_st && (state_q != ST_RD);
  assign we_n  = !(dq_oe && !hi_q);
  assign re_n  = !((state_q == ST_RD) && !hi_q);
  assign dq_o  = (state_q == ST_CMD) ? (wr_q ? OPC_SET : OPC_GET) :
                 (state_q == ST_ADR) ? addr_q : wdata_q[{idx_q, 3'b000} +: 8];
  assign busy  = (state_q != ST_IDLE);
  assign done  = (state_q == ST_DONE);
  assign err   = done && err_q;
  assign rdata = rdata_q;
  assign txn_ecc    = ecc_q;
  assign txn_ecc_en = ecen_q;

  // R10
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R10
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R2
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);

endmodule

// File: rtl/nand_feat_seq.sv
`timescale 1ns/1ps
module nand_feat_seq
  import nfs_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_ADL_NS      = 70,
  parameter int T_WB_NS       = 100,
  parameter int T_FIX_NS      = 600,
  parameter int TIMEOUT_CYC   = 5000,
  parameter int STROBE_CYC    = 1,
  parameter int USE_RB        = 1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  input  logic        ecc_req_valid,
  input  logic        ecc_req_en,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata,
  output logic        ecc_on,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb_n
);

  localparam int ADL_CYC  = ns_to_cyc(T_ADL_NS, CLK_PERIOD_NS);
  localparam int WB_CYC   = ns_to_cyc(T_WB_NS, CLK_PERIOD_NS) + SYNC_STAGES;
  localparam int FIX_CYC  = ns_to_cyc(T_FIX_NS, CLK_PERIOD_NS);
  localparam int WAIT_CYC = (USE_RB != 0) ? TIMEOUT_CYC : FIX_CYC;
  localparam int CW = $clog2(WAIT_CYC + ADL_CYC + WB_CYC + STROBE_CYC + 4) + 1;

  logic          rb_ready, tmr_load, tmr_expired, txn_ecc, txn_ecc_en;
  logic [CW-1:0] tmr_val;
  logic          ecc_on_q, ecc_on_d;

  nfs_sync #(.STAGES(SYNC_STAGES)) rb_sync_i (
    .clk(clk), .rst_n(rst_n), .d(nand_rb_n), .q(rb_ready));

  nfs_delay #(.CW(CW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired));

  nfs_seq #(
    .STROBE_CYC(STROBE_CYC), .ADL_CYC(ADL_CYC), .WB_CYC(WB_CYC),
    .WAIT_CYC(WAIT_CYC), .USE_RB(USE_RB), .CW(CW)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .ecc_req_valid(ecc_req_valid),
    .ecc_req_en(ecc_req_en), .rb_ready(rb_ready), .dq_i(nand_dq_i),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .txn_ecc(txn_ecc), .txn_ecc_en(txn_ecc_en));

  always_comb begin
    ecc_on_d = ecc_on_q;
    if (done && !err && txn_ecc) ecc_on_d = txn_ecc_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecc_on_q <= 1'b0;
    else        ecc_on_q <= ecc_on_d;
  end

  assign ecc_on = ecc_on_q;

  // R9
  ecc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_on != $past(ecc_on)) |-> $past(done));
  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe));

endmodule

// File: tb/nand_feat_seq_tb_top.sv
`timescale 1ns/1ps
module nand_feat_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0, ecc_req_valid = 0, ecc_req_en = 0;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        busy, done, err, ecc_on;
  logic [31:0] rdata;
  logic        ce_n, cle, ale, we_n, re_n, dq_oe, rb_n;
  logic [7:0]  dq_o, dq_i;

  nand_feat_seq #(.TIMEOUT_CYC(200), .USE_RB(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ecc_req_valid(ecc_req_valid),
    .ecc_req_en(ecc_req_en), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .ecc_on(ecc_on), .nand_ce_n(ce_n), .nand_cle(cle),
    .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n), .nand_dq_o(dq_o),
    .nand_dq_oe(dq_oe), .nand_dq_i(dq_i), .nand_rb_n(rb_n));

  // second instance: fixed delay, ready/busy tied busy
  logic        fx_req = 0, fx_busy, fx_done, fx_err, fx_ecc;
  logic [31:0] fx_rdata;
  logic        fx_ce_n, fx_cle, fx_ale, fx_we_n, fx_re_n, fx_oe;
  logic [7:0]  fx_dq_o;
  nand_feat_seq #(.T_FIX_NS(600), .USE_RB(0)) dut_fx (
    .clk(clk), .rst_n(rst_n), .req_valid(fx_req), .req_write(1'b0),
    .req_addr(8'h21), .req_wdata(32'h0), .ecc_req_valid(1'b0),
    .ecc_req_en(1'b0), .busy(fx_busy), .done(fx_done), .err(fx_err),
    .rdata(fx_rdata), .ecc_on(fx_ecc), .nand_ce_n(fx_ce_n), .nand_cle(fx_cle),
    .nand_ale(fx_ale), .nand_we_n(fx_we_n), .nand_re_n(fx_re_n),
    .nand_dq_o(fx_dq_o), .nand_dq_oe(fx_oe), .nand_dq_i(8'hA5),
    .nand_rb_n(1'b0));

  // ---------------- device model ----------------
  int          cyc = 0, rb_start = 0, rb_end = 0, blen = 5;
  int          n_cmd = 0, n_addr = 0, n_re = 0, nwr = 0;
  int          addr_cyc = 0, wr1_cyc = 0, re1_cyc = 0;
  logic [7:0]  m_opc = 0, m_addr = 0;
  logic [31:0] m_wword = 0, rword = 0;
  logic [2:0]  ridx = 0;
  logic        prev_we = 1, prev_re = 1;

  assign rb_n = !((cyc >= rb_start) && (cyc < rb_end));
  assign dq_i = !re_n ? rword[{ridx[1:0], 3'b000} +: 8] : 8'h00;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!prev_we && we_n) begin
      if (cle) begin
        m_opc = dq_o; n_cmd = n_cmd + 1; nwr = 0; ridx = 0; m_wword = 0; re1_cyc = 0;
      end else if (ale) begin
        m_addr = dq_o; n_addr = n_addr + 1; addr_cyc = cyc;
        if (m_opc == 8'hEE) begin rb_start = cyc + 1; rb_end = cyc + 1 + blen; end
      end else begin
        m_wword[nwr*8 +: 8] = dq_o;
        if (nwr == 0) wr1_cyc = cyc;
        nwr = nwr + 1;
        if (nwr == 4) begin rb_start = cyc + 1; rb_end = cyc + 1 + blen; end
      end
    end
    if (prev_re && !re_n && ridx == 0) re1_cyc = cyc;
    if (!prev_re && re_n) begin ridx = ridx + 1; n_re = n_re + 1; end
    prev_we = we_n; prev_re = re_n;
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_bad = 0, done_cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int g = 0;
    while (!done && g < 5000) begin @(negedge clk); g++; end
    if (!done) check(0, "watchdog", 0, 1);
    done_cyc = cyc;
  endtask

  task automatic issue(input bit wr, input logic [7:0] a, input logic [31:0] w,
                       input bit ecc, input bit een, input bit plain);
    @(negedge clk);
    req_valid = plain; req_write = wr; req_addr = a; req_wdata = w;
    ecc_req_valid = ecc; ecc_req_en = een;
    @(negedge clk);
    req_valid = 0; ecc_req_valid = 0;
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
  endtask

  task automatic wait_rb();
    while (!rb_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // {write, addr, wdata, device read word, busy length}
  localparam logic [88:0] VEC [6] = '{
    {1'b1, 8'h01, 32'h4433_2211, 32'h0, 16'd5},
    {1'b0, 8'h01, 32'h0, 32'hDDCC_BBAA, 16'd10},
    {1'b1, 8'hFF, 32'h8000_0001, 32'h0, 16'd3},
    {1'b0, 8'h00, 32'h0, 32'h0102_0304, 16'd40},
    {1'b1, 8'h5A, 32'hFFFF_FFFF, 32'h0, 16'd150},
    {1'b0, 8'hA7, 32'h0, 32'h00FF_807F, 16'd3}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 0 && done == 0 && ecc_on == 0, "R9 reset", {busy, done, ecc_on}, 0);
    check(ce_n && we_n && re_n && !cle && !ale && !dq_oe, "R10 idle bus",
          {ce_n, we_n, re_n, cle, ale, dq_oe}, 6'b111000);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic        vw;
      logic [7:0]  va;
      logic [31:0] vd;
      int          c0, a0, r0;
      vw = VEC[i][88]; va = VEC[i][87:80]; vd = VEC[i][79:48];
      rword = VEC[i][47:16]; blen = int'(VEC[i][15:0]);
      c0 = n_cmd; a0 = n_addr; r0 = n_re;
      issue(vw, va, vd, 0, 0, 1);
      wait_done();
      check(err == 0, "R6 no error", err, 0);
      check(m_opc == (vw ? 8'hEF : 8'hEE), vw ? "R1 opcode" : "R2 opcode", m_opc, vw ? 8'hEF : 8'hEE);
      check(m_addr == va && n_addr - a0 == 1 && n_cmd - c0 == 1, "R1 single address cycle", m_addr, va);
      if (vw) begin
        check(m_wword == vd && nwr == 4, "R1 parameter order", m_wword, vd);
        check(wr1_cyc - addr_cyc >= 4, "R3 address-to-data gap", wr1_cyc - addr_cyc, 4);
        check(done_cyc >= rb_end, "R4 done after ready", done_cyc, rb_end);
      end else begin
        check(rdata == rword && n_re - r0 == 4, "R2 read data order", rdata, rword);
        check(re1_cyc >= rb_end, "R4 read after ready", re1_cyc, rb_end);
      end
      @(negedge clk);
      check(done == 0, "R11 done single cycle", done, 0);
      wait_rb();
    end

    // R8 priority and enable pattern
    blen = 4;
    issue(1, 8'h12, 32'hABCD_0123, 1, 1, 1);
    wait_done();
    check(m_addr == 8'h90 && m_wword == 32'h0000_0008, "R8 ecc enable pattern", m_wword, 32'h8);
    check(ecc_on == 0, "R9 flag before update", ecc_on, 0);
    @(negedge clk);
    check(ecc_on == 1, "R9 flag set", ecc_on, 1);
    wait_rb();
    issue(1, 8'h00, 32'h0, 1, 0, 0);
    wait_done();
    check(m_addr == 8'h90 && m_wword == 32'h0 && m_opc == 8'hEF, "R8 ecc disable pattern", m_wword, 0);
    @(negedge clk);
    check(ecc_on == 0, "R9 flag cleared", ecc_on, 0);
    wait_rb();

    // R7 requests while busy ignored
    begin
      int c0;
      blen = 20; c0 = n_cmd;
      issue(0, 8'h33, 32'h0, 0, 0, 1);
      repeat (2) @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = 8'h44; ecc_req_valid = 1; ecc_req_en = 1;
      @(negedge clk);
      req_valid = 0; ecc_req_valid = 0;
      wait_done();
      repeat (10) @(negedge clk);
      check(n_cmd - c0 == 1 && m_addr == 8'h33, "R7 busy ignores requests", n_cmd - c0, 1);
      check(busy == 0 && ecc_on == 0, "R7 idle afterwards, R9 unchanged", {busy, ecc_on}, 0);
      wait_rb();
    end

    // R6 timeout on get, then on an ecc enable
    begin
      int r0;
      blen = 400; r0 = n_re;
      issue(0, 8'h07, 32'h0, 0, 0, 1);
      wait_done();
      check(err == 1, "R6 timeout error", err, 1);
      check(n_re == r0, "R6 no read strobes", n_re - r0, 0);
      wait_rb();
      issue(1, 8'h00, 32'h0, 1, 1, 0);
      wait_done();
      check(err == 1, "R6 timeout on ecc request", err, 1);
      @(negedge clk);
      check(ecc_on == 0, "R9 flag kept after error", ecc_on, 0);
      wait_rb();
    end

    // R5 fixed-delay variant ignores ready/busy
    begin
      int g = 0;
      @(negedge clk); fx_req = 1;
      @(negedge clk); fx_req = 0;
      while (!fx_done && g < 5000) begin @(negedge clk); g++; end
      check(fx_done == 1 && fx_err == 0, "R5 fixed wait completes", {fx_done, fx_err}, 2'b10);
      check(g >= 30, "R5 fixed wait length", g, 30);
      check(fx_rdata == 32'hA5A5_A5A5, "R5 read after fixed wait", fx_rdata, 32'hA5A5_A5A5);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule